// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-management master of an Ethernet port. Software sees four 32-bit registers: configuration/status, control, address and data. The serial side drives the management clock and a tri-stated data line made of an output, an output enable and an input. One controller handles both clause 22 and clause 45 framing. Software writes a register to start each phase of an access. It then polls a busy flag, and after a read it checks an error flag before using the data register.

In clause 22 mode the device field of the control register holds the PHY register number, and a read or write takes a single frame. In clause 45 mode the device field holds the MMD number. A write to the address register sends an address frame, and a later control write (read) or data write (write) sends the access frame. Every frame has 64 bit slots: 32 preamble ones, start, opcode, port address, device address, a two-bit turnaround and 16 data bits, most significant bit first.

Top module: `mdio_master`

## Requirements
- R1: Register word offsets on `bus_addr` are 0 configuration, 1 control, 2 address and 3 data. In the configuration word, bits [7:0] are the clock divider, bit 8 selects the inverted edge, bit 9 enables clause 45, bit 30 is the read error (read-only) and bit 31 is busy (read-only). In the control word, bits [4:0] are the device/register address, bits [9:5] are the port address and bit 15 is the read trigger, which reads back as 0. After reset every register reads 0, `mdc` is 1 and `mdio_oe` is 0.
- R2: The MDC period is 2×(divider+1) system clocks. `mdc` stays high while no frame runs. A frame lasts 64 MDC periods.
- R3: These writes store their fields and start no frame: a configuration write, a control write with bit 15 clear, and an address write in clause 22 mode.
- R4: In clause 22 mode, a control write with bit 15 set sends a read frame with start 01, opcode 10, the written port and the written register number. The 16 bits the PHY returns are loaded into data bits [15:0], and bits [31:16] read 0.
- R5: In clause 22 mode, a data write sends start 01, opcode 01, the stored port and register number, turnaround 10, and the written low 16 bits as payload.
- R6: In clause 45 mode, an address write sends start 00, opcode 00 and turnaround 10, with the written 16-bit value as payload.
- R7: In clause 45 mode, a control read sends start 00, opcode 11, and a data write sends start 00, opcode 01.
- R8: Busy reads 1 from the cycle after a frame starts until the frame ends. Any register write accepted while busy is 1 is ignored: no field changes and no frame starts.
- R9: On a read, if `mdio_i` is not low when the second turnaround bit is sampled, the read-error bit is set. It stays set until the next frame starts, and starting any frame clears it.
- R10: `mdio_oe` is 0 while idle. On a read frame it is also 0 from the first turnaround bit through the last data bit. On write and address frames it stays 1 for the whole frame.
- R11: With bit 8 clear, `mdio_o` changes on the falling MDC edge and `mdio_i` is sampled on the rising edge. With bit 8 set, the two edges swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data returned the next cycle |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in (already synchronous to clk) |

## Verification
A read frame finishing and a software write to the data register can land on the same clock edge. On that edge the captured PHY bits load the data register while busy is still high, so the write must be refused. The bench starts a clause 22 read with divider 0, counts exactly 128 clocks, and puts a data write on the final edge. It then checks that the data register holds the PHY value and that no extra frame appeared on the wire. A second run moves the write one clock later and checks that this time the write is accepted and sent as a frame carrying its payload.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int TA_LAST    = 47;
  localparam int DATA_FIRST = 48;

  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  port;
    logic [4:0]  dev;
    logic [15:0] payload;
    logic        rd;
  } mdio_req_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_req_t r);
    logic [1:0]  ta;
    logic [15:0] dat;
    ta  = r.rd ? 2'b11 : 2'b10;
    dat = r.rd ? 16'hFFFF : r.payload;
    return {32'hFFFF_FFFF, r.st, r.op, r.port, r.dev, ta, dat};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == div) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  mdio_req_t   req,
  input  logic        neg_edge,
  input  logic        tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_err,
  output logic        rd_done,
  output logic [15:0] rd_word
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] frame;
  logic [FRAME_BITS-2:0] shreg;
  logic [IDX_W-1:0]      bidx;
  logic                  half;
  logic                  is_rd;
  logic                  neg_q;

  assign frame   = build_frame(req);
  // read data is complete when the final half of the last bit ends
  assign rd_done = busy && tick && half && is_rd && (bidx == IDX_W'(FRAME_BITS-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      mdc     <= 1'b1;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_err  <= 1'b0;
      shreg   <= '0;
      bidx    <= '0;
      half    <= 1'b0;
      is_rd   <= 1'b0;
      neg_q   <= 1'b0;
      rd_word <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      half    <= 1'b0;
      bidx    <= '0;
      shreg   <= frame[FRAME_BITS-2:0];
      mdio_o  <= frame[FRAME_BITS-1];
      mdio_oe <= 1'b1;
      mdc     <= neg_edge;
      is_rd   <= req.rd;
      neg_q   <= neg_edge;
      rd_err  <= 1'b0;
    end else if (busy && tick) begin
      if (!half) begin
        // sample phase
        half <= 1'b1;
        mdc  <= !neg_q;
        if (is_rd && bidx == IDX_W'(TA_LAST)) rd_err <= mdio_i;
        if (is_rd && bidx >= IDX_W'(DATA_FIRST)) rd_word <= {rd_word[14:0], mdio_i};
      end else begin
        // drive phase of the next bit, or end of frame
        half <= 1'b0;
        if (bidx == IDX_W'(FRAME_BITS-1)) begin
          busy    <= 1'b0;
          mdc     <= 1'b1;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bidx   <= bidx + 1'b1;
          mdio_o <= shreg[FRAME_BITS-2];
          shreg  <= {shreg[FRAME_BITS-3:0], 1'b1};
          mdc    <= neg_q;
          if (is_rd && bidx == IDX_W'(TA_FIRST-1)) mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam logic [1:0] OFS_CFG  = 2'd0;
  localparam logic [1:0] OFS_CTL  = 2'd1;
  localparam logic [1:0] OFS_ADR  = 2'd2;
  localparam logic [1:0] OFS_DAT  = 2'd3;
  localparam int         RD_BIT   = 15;

  logic [DIV_W-1:0] div_q;
  logic             neg_q;
  logic             c45_q;
  logic [4:0]       port_q;
  logic [4:0]       dev_q;
  logic [15:0]      addr_q;
  logic [15:0]      data_q;

  logic             busy;
  logic             rd_err;
  logic             rd_done;
  logic [15:0]      rd_word;
  logic             tick;
  logic             accept;
  logic             start;
  mdio_req_t        req;
  logic [31:0]      cfg_word;
  logic             unused_bits;

  assign unused_bits = ^{bus_wdata[31:16], bus_wdata[14:10]};
  assign accept      = bus_wr && !busy;

  always_comb begin
    start       = 1'b0;
    req.st      = c45_q ? 2'b00 : 2'b01;
    req.op      = 2'b01;
    req.port    = port_q;
    req.dev     = dev_q;
    req.payload = bus_wdata[15:0];
    req.rd      = 1'b0;
    unique case (bus_addr)
      OFS_CTL: begin
        start       = accept && bus_wdata[RD_BIT];
        req.op      = c45_q ? 2'b11 : 2'b10;
        req.port    = bus_wdata[9:5];
        req.dev     = bus_wdata[4:0];
        req.payload = 16'hFFFF;
        req.rd      = 1'b1;
      end
      OFS_ADR: begin
        start  = accept && c45_q;
        req.st = 2'b00;
        req.op = 2'b00;
      end
      OFS_DAT: start = accept;
      default: start = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      neg_q  <= 1'b0;
      c45_q  <= 1'b0;
      port_q <= '0;
      dev_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (accept) begin
        unique case (bus_addr)
          OFS_CFG: begin
            div_q <= bus_wdata[DIV_W-1:0];
            neg_q <= bus_wdata[8];
            c45_q <= bus_wdata[9];
          end
          OFS_CTL: begin
            port_q <= bus_wdata[9:5];
            dev_q  <= bus_wdata[4:0];
          end
          OFS_ADR: addr_q <= bus_wdata[15:0];
          default: data_q <= bus_wdata[15:0];
        endcase
      end
      if (rd_done) data_q <= rd_word;
    end
  end

  always_comb begin
    cfg_word              = '0;
    cfg_word[31]          = busy;
    cfg_word[30]          = rd_err;
    cfg_word[9]           = c45_q;
    cfg_word[8]           = neg_q;
    cfg_word[DIV_W-1:0]   = div_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        OFS_CFG: bus_rdata <= cfg_word;
        OFS_CTL: bus_rdata <= {22'd0, port_q, dev_q};
        OFS_ADR: bus_rdata <= {16'd0, addr_q};
        default: bus_rdata <= {16'd0, data_q};
      endcase
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (div_q),
    .tick (tick)
  );

  mdio_frame_engine u_eng (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .req      (req),
    .neg_edge (neg_q),
    .tick     (tick),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_err   (rd_err),
    .rd_done  (rd_done),
    .rd_word  (rd_word)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             busy,
  input logic             rd_err,
  input logic             mdc,
  input logic             mdio_oe,
  input logic [DIV_W-1:0] div_q,
  input logic             neg_q,
  input logic             c45_q
);
  assert_idle_lines_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mdc && !mdio_oe));

  assert_start_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_wr));

  assert_mdc_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdc) |-> (busy || $past(busy)));

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable({div_q, neg_q, c45_q}));

  assert_err_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_err) |-> busy);

  assert_err_clear_on_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !rd_err);
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  typedef struct packed {
    logic        c45;
    logic [1:0]  kind;   // 0 read, 1 write, 2 address
    logic [4:0]  port;
    logic [4:0]  dev;
    logic [15:0] val;
    logic        ack;
    logic [7:0]  div;
    logic        neg;
  } vec_t;

  localparam int NVEC = 6;
  localparam logic [38:0] VEC [0:NVEC-1] = '{
    {1'b0, 2'd0, 5'd3,  5'd2,  16'hBEEF, 1'b1, 8'd1, 1'b0},
    {1'b0, 2'd1, 5'd31, 5'd0,  16'hA5C3, 1'b1, 8'd0, 1'b0},
    {1'b1, 2'd2, 5'd1,  5'd30, 16'h1234, 1'b1, 8'd2, 1'b0},
    {1'b1, 2'd0, 5'd1,  5'd30, 16'h5A0F, 1'b1, 8'd1, 1'b1},
    {1'b1, 2'd1, 5'd16, 5'd7,  16'h0F0F, 1'b1, 8'd1, 1'b1},
    {1'b0, 2'd0, 5'd0,  5'd31, 16'h0000, 1'b0, 8'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  mdio_master u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #5 clk = ~clk;

  // PHY model and wire monitors
  logic        tb_neg = 1'b0;
  logic        phy_ack = 1'b1;
  logic [15:0] phy_val = '0;
  logic        prev_mdc = 1'b1;
  logic        prev_oe = 1'b0;
  int          pcnt = 64;
  logic [63:0] pcap = '0;
  int          frames = 0;
  int          oe_cyc = 0;
  int          cyc = 0;
  int          last_fall = 0;
  int          mdc_per = 0;
  int          edge_bad = 0;

  always @(mdc or mdio_oe) begin
    if (mdio_oe && !prev_oe) begin
      frames = frames + 1;
      pcnt = 0;
      pcap = '0;
    end
    prev_oe = mdio_oe;
    if (mdc !== prev_mdc) begin
      prev_mdc = mdc;
      if (mdc == !tb_neg) begin
        if (pcnt < 64) begin
          pcap[63-pcnt] = mdio_oe ? mdio_o : 1'b0;
          pcnt = pcnt + 1;
        end
      end else begin
        if (pcnt == 47 && pcap[29]) mdio_i = phy_ack ? 1'b0 : 1'b1;
        else if (pcnt >= 48 && pcnt < 64 && pcap[29] && phy_ack) mdio_i = phy_val[63-pcnt];
        else mdio_i = 1'b1;
      end
    end
  end

  always @(negedge clk) cyc = cyc + 1;
  always @(posedge clk) if (mdio_oe) oe_cyc = oe_cyc + 1;
  always @(negedge mdc) begin
    mdc_per = cyc - last_fall;
    last_fall = cyc;
  end
  always @(mdio_o) begin
    #1;
    if (mdio_oe && (mdc !== tb_neg)) edge_bad = edge_bad + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    int guard = 0;
    do begin
      bus_read(2'd0, r);
      guard++;
    end while (r[31] && guard < 20000);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [63:0] exp_frame(input logic c45, input logic [1:0] kind,
      input logic [4:0] port, input logic [4:0] dev, input logic [15:0] v);
    logic [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    op = (kind == 2'd0) ? (c45 ? 2'b11 : 2'b10) : (kind == 2'd1) ? 2'b01 : 2'b00;
    return {32'hFFFF_FFFF, st, op, port, dev, 2'b10, (kind == 2'd0) ? 16'h0000 : v};
  endfunction

  initial begin
    #(10 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    int f0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 mdc idle", {63'd0, mdc}, 64'd1);
    chk("R1 oe idle", {63'd0, mdio_oe}, 64'd0);
    bus_read(2'd0, r); chk("R1 cfg reset", {32'd0, r}, 64'd0);
    bus_read(2'd3, r); chk("R1 data reset", {32'd0, r}, 64'd0);

    // R3 field-only writes
    f0 = frames;
    bus_write(2'd0, 32'h0000_0305);
    bus_read(2'd0, r); chk("R3 cfg readback", {32'd0, r}, 64'h305);
    bus_write(2'd1, 32'h0000_0131);
    bus_read(2'd1, r); chk("R3 ctl readback", {32'd0, r}, 64'h131);
    bus_write(2'd0, 32'h0000_0000);
    bus_write(2'd2, 32'h0000_7777);
    repeat (5) @(negedge clk);
    bus_read(2'd2, r); chk("R3 addr readback", {32'd0, r}, 64'h7777);
    chk("R3 no frame", 64'(frames - f0), 64'd0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      logic [63:0] ef, mask;
      int exp_oe;
      v = vec_t'(VEC[i]);
      tb_neg = v.neg; phy_val = v.val; phy_ack = v.ack;
      bus_write(2'd0, {22'd0, v.c45, v.neg, v.div});
      f0 = frames;
      if (v.kind == 2'd0) begin
        oe_cyc = 0;
        bus_write(2'd1, {16'd0, 1'b1, 5'd0, v.port, v.dev});
      end else begin
        bus_write(2'd1, {22'd0, v.port, v.dev});
        oe_cyc = 0;
        bus_write((v.kind == 2'd1) ? 2'd3 : 2'd2, {16'd0, v.val});
      end
      wait_idle();
      ef = exp_frame(v.c45, v.kind, v.port, v.dev, v.val);
      mask = (v.kind == 2'd0) ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
      chk("R2 one frame", 64'(frames - f0), 64'd1);
      chk("R2 mdc period", 64'(mdc_per), 64'(2 * (v.div + 1)));
      exp_oe = (v.kind == 2'd0) ? 92 * (v.div + 1) : 128 * (v.div + 1);
      chk("R10 oe span", 64'(oe_cyc), 64'(exp_oe));
      if (v.c45)
        chk(v.kind == 2'd2 ? "R6 frame" : "R7 frame", pcap & mask, ef & mask);
      else
        chk(v.kind == 2'd0 ? "R4 frame" : "R5 frame", pcap & mask, ef & mask);
      if (v.kind == 2'd0) begin
        bus_read(2'd3, r);
        chk("R4 read data", {32'd0, r}, {48'd0, v.ack ? v.val : 16'hFFFF});
        bus_read(2'd0, r);
        chk("R9 error flag", {63'd0, r[30]}, {63'd0, !v.ack});
      end
    end

    // R9 error cleared at next start
    tb_neg = 1'b0;
    bus_write(2'd0, 32'h0000_0000);
    bus_read(2'd0, r); chk("R9 sticky", {63'd0, r[30]}, 64'd1);
    bus_write(2'd3, 32'h0000_0001);
    bus_read(2'd0, r); chk("R9 cleared", {62'd0, r[31:30]}, 64'd2);
    wait_idle();

    // R8 writes while busy ignored
    f0 = frames;
    bus_write(2'd0, 32'h0000_0002);
    bus_write(2'd3, 32'h0000_1357);
    bus_read(2'd0, r); chk("R8 busy", {63'd0, r[31]}, 64'd1);
    bus_write(2'd0, 32'h0000_0007);
    bus_write(2'd3, 32'h0000_2468);
    wait_idle();
    bus_read(2'd0, r); chk("R8 cfg kept", {32'd0, r}, 64'h2);
    bus_read(2'd3, r); chk("R8 data kept", {32'd0, r}, 64'h1357);
    chk("R8 single frame", 64'(frames - f0), 64'd1);
    chk("R5 payload", {48'd0, pcap[15:0]}, 64'h1357);

    // R8 collision: data write on the final edge of a read frame
    bus_write(2'd0, 32'h0000_0000);
    phy_val = 16'hC0DE; phy_ack = 1'b1;
    f0 = frames;
    bus_write(2'd1, 32'h0000_8044);
    repeat (127) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h0000_1111;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (4) @(negedge clk);
    bus_read(2'd3, r); chk("R8 final edge read wins", {32'd0, r}, 64'hC0DE);
    chk("R8 final edge no frame", 64'(frames - f0), 64'd1);

    // one clock later the write is accepted
    f0 = frames;
    bus_write(2'd1, 32'h0000_8044);
    repeat (128) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h0000_2222;
    @(negedge clk);
    bus_wr = 1'b0;
    wait_idle();
    chk("R8 next edge accepted", 64'(frames - f0), 64'd2);
    chk("R5 next edge payload", {48'd0, pcap[15:0]}, 64'h2222);

    // R11 drive-edge alignment across all frames
    chk("R11 drive edge", 64'(edge_bad), 64'd0);

    summary();
    $finish;
  end
endmodule